// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block holds the two control registers that decide whether a processor core is interrupted: a status word and a cause word. Eight external interrupt lines are sampled into the cause word every cycle. Each sampled line is ANDed with its bit in the mask field of the status word. When the global enable bit is set and any line survives the mask, the block raises a request and reports the number of the highest-numbered surviving line as the winning level.

The core acknowledges a request with a one-cycle take strobe. On a take, the block saves the current mask and enable bit on a four-entry save stack. It then clears every mask bit at or below the winning level, so that only strictly higher levels can nest. It also sets the enable and exception-level bits and writes the interrupt code into the cause word. A one-cycle return strobe pops the stack and restores the mask and enable bit that were in force before the matching take. Software reads both words on dedicated outputs and writes their writable fields through a simple write port.

Top module: `irq_ctl_top`

## Requirements
- R1: While reset is high for a clock edge, both register outputs read zero, and after that edge `irq_req` is 0 and `irq_level` is 0.
- R2: Cause bits 15:8 show the value `pend_i` had at the previous clock edge. Software writes to these bits have no effect.
- R3: `irq_req` is 1 exactly when status bit 0 (enable) is 1 and at least one bit of (cause[15:8] AND status[15:8]) is 1. While the enable bit is 0 there is never a request.
- R4: `irq_level` is the index (0 to 7) of the highest set bit of (cause[15:8] AND status[15:8]). Bit 7 has the highest priority. It reads 0 when no bit is set.
- R5: When a take is accepted, the next cycle shows the following. Status mask bits at and below the level reported at the take are cleared, and the higher mask bits are kept. Status bit 0 (enable) is 1, status bit 1 (exception level) is 1, and cause bits 6:2 read the interrupt code 0.
- R6: An accepted return restores the status mask and enable bit to their values just before the matching take. It clears the exception-level bit when the outermost entry is popped, and leaves it unchanged otherwise.
- R7: Up to four takes can nest. The returns then restore the saved masks in last-in, first-out order.
- R8: Some strobes are ignored and leave both register outputs unchanged: a take while `irq_req` is 0, a take while four entries are already saved, and a return while no entry is saved.
- R9: A write with `wr_sel`=0 loads status bits 0, 1, 4 and 15:8 from `wr_data`. A write with `wr_sel`=1 loads cause bits 31 and 6:2 from `wr_data`. All other bits of both words read 0.
- R10: A return takes precedence over a take in the same cycle. An accepted take or return takes precedence over a write in the same cycle, and that write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | 8 | External interrupt lines, bit 7 highest priority |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select for writes: 0 status, 1 cause |
| wr_data | input | 32 | Write data |
| take_i | input | 1 | Core takes the current request (one-cycle strobe) |
| ret_i | input | 1 | Core returns from the current handler (one-cycle strobe) |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Winning interrupt level |
| status_o | output | 32 | Status word contents |
| cause_o | output | 32 | Cause word contents |

## Verification
A change on `pend_i` reaches cause[15:8] after one clock edge. It reaches `irq_req` and `irq_level` in the same cycle, because both are combinational from the registers. Every accepted take, return or write is visible on `status_o` and `cause_o` after the single edge that samples the strobe. The bench therefore drives each stimulus on a falling edge and lets one rising edge pass. It then compares all four outputs on the next falling edge against a reference model that it advances once per rising edge.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int NLINES   = 8;
    localparam int LVL_W    = $clog2(NLINES);
    localparam int CODE_W   = 5;
    localparam logic [CODE_W-1:0] CODE_IRQ = '0;

    typedef struct packed {
        logic [NLINES-1:0] mask;
        logic              um;
        logic              exl;
        logic              ie;
    } status_t;

    typedef struct packed {
        logic              bd;
        logic [NLINES-1:0] pend;
        logic [CODE_W-1:0] code;
    } cause_t;

    typedef struct packed {
        logic [NLINES-1:0] mask;
        logic              ie;
    } save_t;

    // Word layout: enable 0, exception level 1, user mode 4, mask 15:8.
    function automatic logic [31:0] pack_status(status_t s);
        logic [31:0] w;
        w        = '0;
        w[0]     = s.ie;
        w[1]     = s.exl;
        w[4]     = s.um;
        w[15:8]  = s.mask;
        return w;
    endfunction

    // Word layout: code 6:2, pending 15:8, branch delay 31.
    function automatic logic [31:0] pack_cause(cause_t c);
        logic [31:0] w;
        w        = '0;
        w[6:2]   = c.code;
        w[15:8]  = c.pend;
        w[31]    = c.bd;
        return w;
    endfunction

    // Bits lvl down to 0 set.
    function automatic logic [NLINES-1:0] low_mask(logic [LVL_W-1:0] lvl);
        logic [NLINES-1:0] m;
        for (int i = 0; i < NLINES; i++) begin
            m[i] = (i <= int'(lvl));
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        // Later (higher) indices override earlier ones.
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/irq_save_stack.sv
module irq_save_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 9,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_o,
    output logic         empty,
    output logic         full,
    output logic         last_one
);
    logic [CW-1:0] cnt;
    logic [W-1:0]  mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (pop)  cnt <= cnt - 1'b1;
        else if (push) cnt <= cnt + 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                 mem[g] <= '0;
            else if (push && !pop && cnt == CW'(g))  mem[g] <= push_data;
        end
    end

    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt == CW'(i + 1)) top_o = mem[i];
        end
    end

    assign empty    = (cnt == '0);
    assign full     = (cnt == CW'(DEPTH));
    assign last_one = (cnt == CW'(1));

    a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> full);
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
    import irq_ctl_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       pend_i,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             take_i,
    input  logic             ret_i,
    output logic             irq_req,
    output logic [2:0]       irq_level,
    output logic [31:0]      status_o,
    output logic [31:0]      cause_o
);
    status_t           st_q;
    cause_t            ca_q;
    logic [NLINES-1:0] cand;
    logic              cand_any;
    logic [LVL_W-1:0]  win_idx;
    save_t             stk_top;
    logic              stk_empty, stk_full, stk_last;
    logic              take_ok, ret_ok;
    logic              unused_wr;

    assign cand = ca_q.pend & st_q.mask;

    irq_prio_pick #(.N(NLINES)) u_pick (
        .req_i (cand),
        .any_o (cand_any),
        .idx_o (win_idx)
    );

    assign irq_req   = st_q.ie & cand_any;
    assign irq_level = win_idx;

    assign ret_ok  = ret_i & ~stk_empty;
    assign take_ok = take_i & irq_req & ~ret_i & ~stk_full;

    irq_save_stack #(.DEPTH(DEPTH), .W($bits(save_t))) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (take_ok),
        .pop       (ret_ok),
        .push_data ({st_q.mask, st_q.ie}),
        .top_o     (stk_top),
        .empty     (stk_empty),
        .full      (stk_full),
        .last_one  (stk_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            ca_q <= '0;
        end else begin
            ca_q.pend <= pend_i;
            if (ret_ok) begin
                st_q.mask <= stk_top.mask;
                st_q.ie   <= stk_top.ie;
                if (stk_last) st_q.exl <= 1'b0;
            end else if (take_ok) begin
                st_q.mask <= st_q.mask & ~low_mask(win_idx);
                st_q.ie   <= 1'b1;
                st_q.exl  <= 1'b1;
                ca_q.code <= CODE_IRQ;
            end else if (wr_en) begin
                if (!wr_sel) begin
                    st_q.ie   <= wr_data[0];
                    st_q.exl  <= wr_data[1];
                    st_q.um   <= wr_data[4];
                    st_q.mask <= wr_data[15:8];
                end else begin
                    ca_q.code <= wr_data[6:2];
                    ca_q.bd   <= wr_data[31];
                end
            end
        end
    end

    assign status_o  = pack_status(st_q);
    assign cause_o   = pack_cause(ca_q);
    assign unused_wr = ^{wr_data[30:16], wr_data[7]};

    a_r2_pend_track: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cause_o[15:8] == $past(pend_i));

    a_r3_req_needs_cand: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (status_o[0] && (cause_o[15:8] & status_o[15:8]) != '0));

    a_r4_top_winner: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (((cause_o[15:8] & status_o[15:8]) >> irq_level) == 8'd1));

    a_r5_entry: assert property (@(posedge clk) disable iff (rst)
        take_ok |=> (status_o[0] && status_o[1] && cause_o[6:2] == CODE_IRQ
                     && (status_o[15:8] & low_mask($past(irq_level))) == '0));

    a_r6_restore: assert property (@(posedge clk) disable iff (rst)
        ret_ok |=> (status_o[15:8] == $past(stk_top.mask)
                    && status_o[0] == $past(stk_top.ie)));

    a_r8_empty_return: assert property (@(posedge clk) disable iff (rst)
        (ret_i && stk_empty && !wr_en) |=> $stable(status_o));
endmodule

// File: tb/irq_ctl_top_test.sv
`timescale 1ns/1ps
module irq_ctl_top_test;
    logic        clk = 0;
    logic        rst = 1;
    logic [7:0]  pend_i = '0;
    logic        wr_en = 0, wr_sel = 0, take_i = 0, ret_i = 0;
    logic [31:0] wr_data = '0;
    logic        irq_req;
    logic [2:0]  irq_level;
    logic [31:0] status_o, cause_o;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    irq_ctl_top uut (
        .clk(clk), .rst(rst), .pend_i(pend_i), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .take_i(take_i), .ret_i(ret_i), .irq_req(irq_req),
        .irq_level(irq_level), .status_o(status_o), .cause_o(cause_o)
    );

    // Reference model
    logic [7:0] m_mask, m_pend;
    logic       m_ie, m_exl, m_um, m_bd;
    logic [4:0] m_code;
    logic [7:0] s_mask [4];
    logic       s_ie   [4];
    int         s_cnt;

    function automatic logic [2:0] m_lvl();
        logic [2:0] l = 0;
        for (int i = 0; i < 8; i++) if (m_pend[i] & m_mask[i]) l = 3'(i);
        return l;
    endfunction
    function automatic logic m_req();
        return m_ie && ((m_pend & m_mask) != 0);
    endfunction
    function automatic logic [31:0] m_status();
        return {16'd0, m_mask, 3'd0, m_um, 2'd0, m_exl, m_ie};
    endfunction
    function automatic logic [31:0] m_cause();
        return {m_bd, 15'd0, m_pend, 1'b0, m_code, 2'd0};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "status", status_o, m_status());
        check(tag, "cause", cause_o, m_cause());
        check(tag, "irq_req", 32'(irq_req), 32'(m_req()));
        check(tag, "irq_level", 32'(irq_level), 32'(m_lvl()));
    endtask

    task automatic step(string tag, logic tk, logic rt, logic we, logic ws,
                        logic [31:0] wd, logic [7:0] pd);
        logic req, tk_ok, rt_ok;
        logic [2:0] lvl;
        take_i = tk; ret_i = rt; wr_en = we; wr_sel = ws; wr_data = wd; pend_i = pd;
        @(posedge clk);
        req = m_req(); lvl = m_lvl();
        rt_ok = rt && s_cnt > 0;
        tk_ok = tk && req && !rt && s_cnt < 4;
        if (rt_ok) begin
            m_mask = s_mask[s_cnt-1];
            m_ie   = s_ie[s_cnt-1];
            if (s_cnt == 1) m_exl = 0;
            s_cnt--;
        end else if (tk_ok) begin
            s_mask[s_cnt] = m_mask; s_ie[s_cnt] = m_ie; s_cnt++;
            for (int i = 0; i < 8; i++) if (i <= int'(lvl)) m_mask[i] = 0;
            m_ie = 1; m_exl = 1; m_code = 0;
        end else if (we) begin
            if (!ws) begin
                m_ie = wd[0]; m_exl = wd[1]; m_um = wd[4]; m_mask = wd[15:8];
            end else begin
                m_bd = wd[31]; m_code = wd[6:2];
            end
        end
        m_pend = pd;
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_mask = 0; m_pend = 0; m_ie = 0; m_exl = 0; m_um = 0; m_bd = 0; m_code = 0;
        s_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1");
        rst = 0;

        // R9: write all ones to both words, only defined fields stick
        step("R9", 0, 0, 1, 0, 32'hFFFF_FFFF, 8'h00);
        check("R9", "status word", status_o, 32'h0000_FF13);
        step("R9", 0, 0, 1, 1, 32'hFFFF_FFFF, 8'h00);
        check("R9", "cause word", cause_o, 32'h8000_007C);
        // R2: pending appears one edge later, write to its field ignored
        step("R2", 0, 0, 1, 1, 32'h0000_FF00, 8'hA5);
        check("R2", "pending field", {24'd0, cause_o[15:8]}, 32'hA5);
        check("R2", "code after write", {27'd0, cause_o[6:2]}, 32'd0);
        // R3: enable cleared blocks request
        step("R3", 0, 0, 1, 0, 32'h0000_FF00, 8'hA5);
        check("R3", "no req with ie=0", 32'(irq_req), 0);
        check("R4", "level with ie=0", 32'(irq_level), 7);
        // R8: take without request ignored
        step("R8", 1, 0, 0, 0, 0, 8'hA5);
        // Enable, mask all; build a 4-deep nest
        step("R3", 0, 0, 1, 0, 32'h0000_FF01, 8'h02);
        check("R4", "level 1", 32'(irq_level), 1);
        step("R5", 1, 0, 0, 0, 0, 8'h0A);
        check("R5", "mask after level 1", {24'd0, status_o[15:8]}, 32'hFC);
        step("R5", 1, 0, 0, 0, 0, 8'h2A);
        step("R5", 1, 0, 0, 0, 0, 8'hAA);
        step("R7", 1, 0, 0, 0, 0, 8'hAA);
        check("R7", "mask after 4 takes", {24'd0, status_o[15:8]}, 32'h00);
        // R8: full stack blocks fifth take
        step("R8", 0, 0, 1, 0, 32'h0000_FF03, 8'hAA);
        step("R8", 1, 0, 0, 0, 0, 8'hAA);
        check("R8", "take on full ignored", status_o, 32'h0000_FF03);
        step("R7", 0, 1, 0, 0, 0, 8'hAA);
        check("R7", "pop 1", {24'd0, status_o[15:8]}, 32'hC0);
        step("R7", 0, 1, 0, 0, 0, 8'hAA);
        check("R7", "pop 2", {24'd0, status_o[15:8]}, 32'hF0);
        step("R6", 0, 1, 0, 0, 0, 8'hAA);
        step("R6", 0, 1, 0, 0, 0, 8'hAA);
        check("R6", "outermost pop", status_o, 32'h0000_FF01);
        step("R8", 0, 1, 0, 0, 0, 8'hAA);
        check("R8", "return on empty", status_o, 32'h0000_FF01);
        // R10: take beats a write; return beats a take
        step("R10", 1, 0, 1, 0, 32'h0000_0000, 8'h10);
        check("R10", "write dropped on take", {24'd0, status_o[15:8]}, 32'h00);
        step("R10", 1, 1, 0, 0, 0, 8'h10);
        check("R10", "return wins", status_o, 32'h0000_FF01);

        // Random mix
        for (int k = 0; k < 600; k++) begin
            logic tk, rt, we;
            tk = ($urandom % 3) == 0;
            rt = ($urandom % 4) == 0;
            we = ($urandom % 6) == 0;
            step("R3", tk, rt, we, 1'($urandom), $urandom, 8'($urandom));
        end
        // Flush back to empty and recheck
        for (int k = 0; k < 5; k++) step("R6", 0, 1, 0, 0, 0, 8'h00);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule